// File: doc/BRIEF.md
# Atomic-Pattern Point-Operation Sequencer

This block is the main-loop controller of a prime-field elliptic-curve scalar multiplication that walks the scalar from the most significant bit down, in double-and-add order. Every point operation runs as one fixed 109-cycle atomic pattern. Each scalar bit gets a doubling pattern, and a 1 bit gets an addition pattern straight after it. The field arithmetic sits outside the block. It follows the pattern type and the cycle index that this block publishes.

Inside a pattern, a small schedule marks the cycles in which the atomic pattern has no field multiplication of its own. In those cycles the sequencer raises a dummy-multiply flag instead of the real-multiply enable. The multiplier is then fed a throw-away partial product, so its activity looks the same in every cycle and the quiet cycles say less about which point operation is running. The scalar's leading 1 is handled during initialisation and is not an input. The block takes the remaining `KEY_W-1` bits, latches them on start and pulses done once the final pattern has finished.

Top module: `atom_seq`

## Requirements
- R1: After reset, and while no run is in progress, `done`, `pat_add`, `mul_en` and `mul_dummy` are 0 and `cyc_idx` is 0.
- R2: A `start` pulse while idle latches `key_tail`; the run begins in the next cycle. A `start` (and any `key_tail` change) during a run has no effect on the pattern sequence.
- R3: Every pattern lasts exactly 109 cycles, and `cyc_idx` counts 1, 2, ..., 109 within it.
- R4: `key_tail` bits are processed from bit `KEY_W-2` down to bit 0. A 0 bit gives one doubling pattern (`pat_add`=0). A 1 bit gives a doubling pattern immediately followed by an addition pattern (`pat_add`=1).
- R5: In pattern cycles 11 to 13, 24, 71 to 75 and 86 to 91, `mul_dummy`=1 and `mul_en`=0.
- R6: In all other pattern cycles, `mul_en`=1 and `mul_dummy`=0.
- R7: Exactly one of `mul_en` and `mul_dummy` is 1 in every pattern cycle, and neither is 1 outside a run.
- R8: `done` is high for exactly one cycle, the cycle right after cycle 109 of the final pattern. A run has 109 × (`KEY_W`-1 + number of 1 bits in `key_tail`) active cycles.
- R9: Asserting `rst` during a run abandons it. The outputs return to the R1 state at the next clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin a run (honoured only when idle) |
| key_tail | input | KEY_W-1 | Scalar bits below the implicit leading 1 |
| done | output | 1 | One-cycle pulse after the final pattern |
| pat_add | output | 1 | Current pattern: 0 doubling, 1 addition |
| cyc_idx | output | 7 | Cycle within the pattern, 1..109; 0 when idle |
| mul_en | output | 1 | Real field multiplication in this cycle |
| mul_dummy | output | 1 | Dummy partial multiplication in this cycle |

## Verification
The bound checker watches, on every cycle, that real and dummy multiplies never overlap and stay silent when idle. It also checks that the cycle index steps by one, that a run opens with a doubling, that an addition only follows a completed doubling, and that done is a single pulse after cycle 109. Whether the pattern order matches the scalar bit by bit, that the total length matches the weight of the scalar, that a start during a run is ignored and that the full idle-slot map is right can only be shown by the bench's scenarios. Those scenarios use fixed vectors, the all-ones tail, random scalars and a mid-run reset.

// File: rtl/atom_pkg.sv
package atom_pkg;

    localparam int PAT_LEN = 109;
    localparam int CYC_W   = $clog2(PAT_LEN + 1);

    typedef enum logic {
        PAT_DBL = 1'b0,
        PAT_ADD = 1'b1
    } pat_kind_e;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_RUN  = 2'd1,
        ST_FIN  = 2'd2
    } seq_state_e;

    typedef struct packed {
        logic real_mul;
        logic dummy_mul;
    } mul_slot_t;

    // Cycles (1-based) of a pattern that carry no field multiplication.
    function automatic logic slot_is_quiet(input logic [CYC_W-1:0] c);
        int ci;
        ci = int'(c);
        return (ci >= 11 && ci <= 13) || (ci == 24) ||
               (ci >= 71 && ci <= 75) || (ci >= 86 && ci <= 91);
    endfunction

endpackage

// File: rtl/atom_cyc_ctr.sv
module atom_cyc_ctr
    import atom_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             restart,
    input  logic             halt,
    output logic [CYC_W-1:0] cyc,
    output logic             last
);

    always_ff @(posedge clk) begin
        if (rst)          cyc <= '0;
        else if (restart) cyc <= CYC_W'(1);
        else if (halt)    cyc <= '0;
        else              cyc <= cyc + 1'b1;
    end

    assign last = (cyc == CYC_W'(PAT_LEN));

endmodule

// File: rtl/atom_bit_walker.sv
module atom_bit_walker #(
    parameter int KEY_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             load,
    input  logic             advance,
    input  logic [KEY_W-2:0] tail,
    output logic             cur_bit,
    output logic             last_bit
);

    localparam int CNT_W = (KEY_W > 2) ? $clog2(KEY_W) : 1;

    logic [KEY_W-2:0] sreg;
    logic [CNT_W-1:0] remain;

    always_ff @(posedge clk) begin
        if (rst) begin
            sreg   <= '0;
            remain <= '0;
        end else if (load) begin
            sreg   <= tail;
            remain <= CNT_W'(KEY_W - 2);
        end else if (advance) begin
            sreg   <= sreg << 1;
            remain <= remain - 1'b1;
        end
    end

    assign cur_bit  = sreg[KEY_W-2];
    assign last_bit = (remain == '0);

endmodule

// File: rtl/atom_mul_sched.sv
module atom_mul_sched
    import atom_pkg::*;
(
    input  logic             active,
    input  logic [CYC_W-1:0] cyc,
    output mul_slot_t        slot
);

    logic quiet;

    always_comb begin
        quiet          = slot_is_quiet(cyc);
        slot.real_mul  = active & ~quiet;
        slot.dummy_mul = active &  quiet;
    end

endmodule

// File: rtl/atom_seq.sv
module atom_seq
    import atom_pkg::*;
#(
    parameter int KEY_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start,
    input  logic [KEY_W-2:0] key_tail,
    output logic             done,
    output logic             pat_add,
    output logic [6:0]       cyc_idx,
    output logic             mul_en,
    output logic             mul_dummy
);

    seq_state_e       state;
    pat_kind_e        kind;
    logic [CYC_W-1:0] cyc;
    logic             last_cyc;
    logic             cur_bit, last_bit;
    logic             active, pat_end, finish, to_add;
    logic             launch, ctr_restart, ctr_halt, walk_adv;
    mul_slot_t        slot;

    assign active  = (state == ST_RUN);
    assign launch  = (state == ST_IDLE) && start;
    assign pat_end = active && last_cyc;
    assign to_add  = (kind == PAT_DBL) && cur_bit;
    assign finish  = !to_add && last_bit;

    assign ctr_restart = launch || (pat_end && !finish);
    assign ctr_halt    = !active || (pat_end && finish);
    assign walk_adv    = pat_end && !to_add && !last_bit;

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= ST_IDLE;
            kind  <= PAT_DBL;
        end else begin
            case (state)
                ST_IDLE: if (start) begin
                    state <= ST_RUN;
                    kind  <= PAT_DBL;
                end
                ST_RUN: if (pat_end) begin
                    if (to_add) begin
                        kind <= PAT_ADD;
                    end else if (last_bit) begin
                        state <= ST_FIN;
                        kind  <= PAT_DBL;
                    end else begin
                        kind <= PAT_DBL;
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    atom_cyc_ctr u_ctr (
        .clk     (clk),
        .rst     (rst),
        .restart (ctr_restart),
        .halt    (ctr_halt),
        .cyc     (cyc),
        .last    (last_cyc)
    );

    atom_bit_walker #(.KEY_W(KEY_W)) u_walk (
        .clk      (clk),
        .rst      (rst),
        .load     (launch),
        .advance  (walk_adv),
        .tail     (key_tail),
        .cur_bit  (cur_bit),
        .last_bit (last_bit)
    );

    atom_mul_sched u_sched (
        .active (active),
        .cyc    (cyc),
        .slot   (slot)
    );

    assign done      = (state == ST_FIN);
    assign pat_add   = active && (kind == PAT_ADD);
    assign cyc_idx   = 7'(cyc);
    assign mul_en    = slot.real_mul;
    assign mul_dummy = slot.dummy_mul;

endmodule

// File: rtl/atom_seq_chk.sv
module atom_seq_chk #(
    parameter int KEY_W = 16
) (
    input logic       clk,
    input logic       rst,
    input logic       done,
    input logic       pat_add,
    input logic [6:0] cyc_idx,
    input logic       mul_en,
    input logic       mul_dummy
);

    logic busy;
    assign busy = mul_en | mul_dummy;

    AST_SLOT_EXCLUSIVE: assert property (@(posedge clk) disable iff (rst)
        !(mul_en && mul_dummy)); // R7

    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (rst)
        (cyc_idx == 7'd0) |-> (!mul_en && !mul_dummy && !pat_add)); // R1

    AST_CYC_STEP: assert property (@(posedge clk) disable iff (rst)
        (busy && cyc_idx != 7'd109) |=> (cyc_idx == $past(cyc_idx) + 7'd1)); // R3

    AST_RUN_OPENS_DBL: assert property (@(posedge clk) disable iff (rst)
        $rose(busy) |-> (cyc_idx == 7'd1 && !pat_add)); // R4

    AST_ADD_AFTER_DBL: assert property (@(posedge clk) disable iff (rst)
        (pat_add && cyc_idx == 7'd1) |-> $past(!pat_add && cyc_idx == 7'd109)); // R4

    AST_DUMMY_SLOT: assert property (@(posedge clk) disable iff (rst)
        (cyc_idx == 7'd13 || cyc_idx == 7'd24) |-> mul_dummy); // R5

    AST_REAL_SLOT: assert property (@(posedge clk) disable iff (rst)
        (cyc_idx == 7'd14 || cyc_idx == 7'd109) |-> mul_en); // R6

    AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (rst)
        done |=> !done); // R8

    AST_DONE_AFTER_END: assert property (@(posedge clk) disable iff (rst)
        done |-> ($past(cyc_idx) == 7'd109 && !busy)); // R8

endmodule

bind atom_seq atom_seq_chk #(.KEY_W(KEY_W)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .done      (done),
    .pat_add   (pat_add),
    .cyc_idx   (cyc_idx),
    .mul_en    (mul_en),
    .mul_dummy (mul_dummy)
);

// File: tb/test_atom_seq.sv
module test_atom_seq;

    localparam int KW = 16;
    localparam int NV = 6;
    localparam logic [KW-2:0] V_TAIL [NV] = '{15'h0000, 15'h7FFF, 15'h0001,
                                             15'h25A5, 15'h1234, 15'h4000};
    localparam int V_NPAT [NV] = '{15, 30, 16, 22, 20, 16};

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          start = 1'b0;
    logic [KW-2:0] key_tail = '0;
    logic          done, pat_add, mul_en, mul_dummy;
    logic [6:0]    cyc_idx;

    int n_chk = 0;
    int n_bad = 0;

    always #10 clk = ~clk;

    atom_seq #(.KEY_W(KW)) i_atom_seq (
        .clk(clk), .rst(rst), .start(start), .key_tail(key_tail),
        .done(done), .pat_add(pat_add), .cyc_idx(cyc_idx),
        .mul_en(mul_en), .mul_dummy(mul_dummy)
    );

    function automatic bit quiet_slot(input int c);
        return (c == 11 || c == 12 || c == 13 || c == 24 ||
                (c >= 71 && c <= 75) || (c >= 86 && c <= 91));
    endfunction

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic chk_idle(input string req);
        chk(!done && !pat_add && !mul_en && !mul_dummy && cyc_idx == 7'd0, req,
            {done, pat_add, mul_en, mul_dummy, cyc_idx}, 0);
    endtask

    // Run one scalar; optionally disturb with a start mid-run (R2).
    task automatic run_seq(input logic [KW-2:0] tail, input int exp_np, input bit disturb);
        bit exp_k [2*KW];
        int ne = 0, pi = 0, n_act = 0, prev = 0, order_err = 0;
        int slot_err = 0, step_err = 0, guard = 0;
        bit seen_done = 0, done_ok = 0;
        for (int b = KW - 2; b >= 0; b--) begin
            exp_k[ne] = 1'b0; ne++;
            if (tail[b]) begin exp_k[ne] = 1'b1; ne++; end
        end
        @(negedge clk);
        key_tail = tail; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        while (!seen_done && guard < 5000) begin
            guard++;
            if (done) begin
                seen_done = 1;
                done_ok = (prev == 109) && !mul_en && !mul_dummy;
            end else if (mul_en || mul_dummy) begin
                n_act++;
                if (mul_en && mul_dummy) slot_err++;
                if (mul_dummy != quiet_slot(int'(cyc_idx))) slot_err++;
                if (!((int'(cyc_idx) == prev + 1) || (prev == 109 && cyc_idx == 7'd1)))
                    step_err++;
                if (cyc_idx == 7'd1) begin
                    if (pi >= ne || pat_add != exp_k[pi]) order_err++;
                    pi++;
                end
                prev = int'(cyc_idx);
            end else begin
                step_err++;
            end
            if (disturb && n_act == 300) begin
                key_tail = ~tail; start = 1'b1;
            end else begin
                start = 1'b0;
            end
            @(negedge clk);
        end
        start = 1'b0;
        chk(order_err == 0 && pi == ne, disturb ? "R2" : "R4", order_err, 0);
        chk(pi == exp_np, "R4", pi, exp_np);
        chk(n_act == 109 * exp_np, "R8", n_act, 109 * exp_np);
        chk(step_err == 0, "R3", step_err, 0);
        chk(slot_err == 0, "R5/R6 R7", slot_err, 0);
        chk(seen_done && done_ok, "R8", done_ok, 1);
        chk(!done, "R8", done, 0);
        chk_idle("R7");
    endtask

    initial begin
        repeat (3) @(negedge clk);
        chk_idle("R1");
        rst = 1'b0;
        @(negedge clk);
        chk_idle("R1");

        // Table of vectors: fixed tails, all-ones tail included.
        for (int v = 0; v < NV; v++) run_seq(V_TAIL[v], V_NPAT[v], 1'b0);

        // Random scalars.
        for (int r = 0; r < 4; r++) begin
            logic [KW-2:0] t;
            t = (KW-1)'($urandom);
            run_seq(t, (KW - 1) + $countones(t), 1'b0);
        end

        // Start during a run is ignored.
        run_seq(15'h1A5C, 15 + $countones(15'h1A5C), 1'b1);

        // Mid-run reset (R9) then a clean run afterwards.
        @(negedge clk);
        key_tail = 15'h7FFF; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        repeat (250) @(negedge clk);
        chk(mul_en || mul_dummy, "R9", mul_en | mul_dummy, 1);
        rst = 1'b1;
        @(negedge clk);
        chk_idle("R9");
        rst = 1'b0;
        @(negedge clk);
        chk_idle("R9");
        run_seq(15'h0003, 17, 1'b0);

        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

endmodule